// File: doc/BRIEF.md
# Programmable-Timing Local Bus Controller

This block runs single read and write transfers on a parallel peripheral bus with one chip-select region. The internal side offers a request (address, write flag, write data) under a valid/ready handshake and gets back a one-clock completion pulse and, for reads, the captured data. The external side drives an address latch enable, an active-low chip select, an active-low read strobe and an active-low write strobe. It also drives a 32-bit address/data bus through a per-bit drive enable, and it samples a ready input.

Every strobe edge is placed by a programmable clock count. The timing fields, the bus mode and the handshake mode are sampled when a request is accepted. In separate-bus mode the low 24 lanes carry the address and the top 8 lanes carry the data. In shared-bus mode all 32 lanes carry the address first and then turn around for data. In fixed-timing mode the chip-select length is exact. In ready-acknowledge mode the chip select is stretched until the device signals ready.

Cycle numbering used below: cycle 0 is the first clock after the edge that accepts a request. The timing fields are aw (latch width), acs (latch to select), csw (select width), coe (select to read strobe), ocs (read strobe end before select end), awr (latch end to write strobe), wrw (write strobe width) and idl (idle clocks). Derived from them: CS_ON = aw+acs and CS_OFF = aw+acs+csw. A valid setting has aw >= 1, csw >= 1, coe+ocs < csw, awr >= acs, awr+wrw <= acs+csw and awr < acs+csw.

Top module: `lbus_ctrl`

## Requirements
- R1: While reset is held and after it is released: bus_ale is 0, bus_cs_n, bus_oe_n and bus_wr_n are 1, bus_oe is all zero, rsp_done is 0 and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from cycle 0 until idl cycles after the first cycle in which chip select is high again. A request held on req_valid during that time is accepted on the first edge where req_ready is 1, not dropped.
- R3: bus_ale is 1 in cycles 0 to aw-1 and 0 otherwise.
- R4: In fixed-timing mode bus_cs_n is 0 in cycles CS_ON to CS_OFF-1 and 1 otherwise.
- R5: On a read, bus_oe_n is 0 in cycles CS_ON+coe to CS_OFF-ocs-1 (fixed mode), and bus_wr_n stays 1 for the whole transfer.
- R6: On a write in fixed mode, bus_wr_n is 0 in cycles aw+awr to aw+awr+wrw-1, and bus_oe_n stays 1 for the whole transfer.
- R7: In separate-bus mode (cfg_mux=0), bits 23:0 carry req_addr[23:0] with drive enabled from cycle 0 until chip select ends. Bits 31:24 carry req_wdata[7:0] over the same span on writes and are not driven on reads. Read data is bus_in[31:24] placed in rsp_rdata[7:0], with the upper bits zero.
- R8: In shared-bus mode (cfg_mux=1), all 32 bits carry req_addr in cycles 0 to CS_ON-1. On a write they then carry req_wdata while chip select is low. On a read they are not driven from CS_ON on. Read data is all 32 bits of bus_in.
- R9: In fixed mode a read samples bus_in at the clock edge that ends cycle CS_OFF-ocs-1. rsp_rdata keeps its value through writes until the next read.
- R10: rsp_done is 1 for exactly one clock: the cycle right after the last chip-select-low cycle. rsp_rdata is already valid in that cycle.
- R11: In acknowledge mode (cfg_ack=1), bus_rdy is sampled from the edge ending cycle CS_OFF-1 onward; values before that have no effect. Chip select and the active read strobe or write strobe stay low until an edge that samples bus_rdy=1, and all of them rise in the next cycle. The read strobe starts at CS_ON+coe and the write strobe at aw+awr, and both end with chip select.
- R12: In acknowledge mode a read samples bus_in at the same edge that samples bus_rdy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mux | input | 1 | 1 = shared address/data bus, 0 = separate lanes |
| cfg_ack | input | 1 | 1 = ready-acknowledge mode, 0 = fixed timing |
| cfg_ale_w | input | 4 | Latch enable width aw |
| cfg_ale_cs | input | 4 | Latch end to chip select acs |
| cfg_cs_w | input | 4 | Minimum chip-select width csw |
| cfg_cs_oe | input | 4 | Chip select to read strobe coe |
| cfg_oe_cs | input | 4 | Read strobe end before chip-select end ocs |
| cfg_ale_wr | input | 4 | Latch end to write strobe awr |
| cfg_wr_w | input | 4 | Write strobe width wrw |
| cfg_idle | input | 4 | Idle clocks after chip select idl |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Captured read data |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_out | output | 32 | Address/data value driven onto the bus |
| bus_oe | output | 32 | Per-bit drive enable for bus_out |
| bus_in | input | 32 | Value seen on the bus |
| bus_rdy | input | 1 | Device ready, used in acknowledge mode |

## Verification
Every bus output depends only on the cycle index counted from the accepting edge, so the bench rebuilds each expected level from the timing fields as an interval test on that index. It checks all outputs at the falling edge of every cycle of the transfer. In acknowledge mode the chip-select end moves back by the number of low ready samples, and the bench shifts its own end point by that amount. bus_in changes value every cycle, so the returned data shows exactly which edge captured it: CS_OFF-ocs-1 in fixed mode, or the ready edge. rsp_done and the new rsp_rdata are checked in the first cycle after chip select, and req_ready is checked to return exactly idl cycles later.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  // Cycle index (counted from cycle 0 = first latch-enable cycle) at which
  // chip select goes low.
  function automatic int cs_on(int aw, int acs);
    return aw + acs;
  endfunction

  // First cycle with chip select high again (minimum width).
  function automatic int cs_off(int aw, int acs, int csw);
    return aw + acs + csw;
  endfunction

  // Number of counted cycles in one transfer, idle cycles included.
  function automatic int xfer_len(int aw, int acs, int csw, int idl);
    return aw + acs + csw + idl;
  endfunction

  function automatic int oe_on(int aw, int acs, int coe);
    return aw + acs + coe;
  endfunction

  // Read strobe end: fixed mode leads chip select by ocs, acknowledge
  // mode ends together with chip select.
  function automatic int oe_off(int aw, int acs, int csw, int ocs, bit ack);
    return ack ? (aw + acs + csw) : (aw + acs + csw - ocs);
  endfunction

  // Write strobe is referenced to the end of the latch enable pulse.
  function automatic int wr_on(int aw, int awr);
    return aw + awr;
  endfunction

  function automatic int wr_off(int aw, int acs, int csw, int awr, int wrw, bit ack);
    return ack ? (aw + acs + csw) : (aw + awr + wrw);
  endfunction

endpackage

// File: rtl/lbus_timer.sv
module lbus_timer #(
  parameter int CW = 4,
  parameter int TW = CW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack,
  input  logic          rdy,
  input  logic [CW-1:0] aw,
  input  logic [CW-1:0] acs,
  input  logic [CW-1:0] csw,
  input  logic [CW-1:0] idl,
  output logic          active,
  output logic [TW-1:0] t,
  output logic          at_cs_last,
  output logic          hold
);

  logic [TW-1:0] t_cs_last;
  logic [TW-1:0] t_end;

  always_comb begin
    t_cs_last = TW'(lbus_pkg::cs_off(int'(aw), int'(acs), int'(csw)) - 1);
    t_end     = TW'(lbus_pkg::xfer_len(int'(aw), int'(acs), int'(csw), int'(idl)) - 1);
  end

  // Last minimum chip-select cycle: the ready sample point in acknowledge mode.
  assign at_cs_last = active && (t == t_cs_last);
  assign hold       = at_cs_last && ack && !rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      t      <= '0;
    end else if (start) begin
      active <= 1'b1;
      t      <= '0;
    end else if (active && !hold) begin
      if (t == t_end) active <= 1'b0;
      else            t      <= t + 1'b1;
    end
  end

  // R11: a low ready sample freezes the cycle counter
  a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (active && $stable(t)));

  // R2: the counter never passes the end of the transfer
  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (t <= t_end));

endmodule

// File: rtl/lbus_strobe.sv
module lbus_strobe #(
  parameter int CW = 4,
  parameter int TW = CW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [TW-1:0] t,
  input  logic          ack,
  input  logic          we,
  input  logic          at_cs_last,
  input  logic          hold,
  input  logic [CW-1:0] aw,
  input  logic [CW-1:0] acs,
  input  logic [CW-1:0] csw,
  input  logic [CW-1:0] coe,
  input  logic [CW-1:0] ocs,
  input  logic [CW-1:0] awr,
  input  logic [CW-1:0] wrw,
  output logic          ale,
  output logic          cs_n,
  output logic          oe_n,
  output logic          wr_n,
  output logic          pre_cs,
  output logic          in_cs,
  output logic          cap_evt,
  output logic          done
);

  int tt;
  int e_cs_on, e_cs_off, e_oe_on, e_oe_off, e_wr_on, e_wr_off;
  logic in_oe, in_wr;

  always_comb begin
    tt       = int'(t);
    e_cs_on  = lbus_pkg::cs_on(int'(aw), int'(acs));
    e_cs_off = lbus_pkg::cs_off(int'(aw), int'(acs), int'(csw));
    e_oe_on  = lbus_pkg::oe_on(int'(aw), int'(acs), int'(coe));
    e_oe_off = lbus_pkg::oe_off(int'(aw), int'(acs), int'(csw), int'(ocs), ack);
    e_wr_on  = lbus_pkg::wr_on(int'(aw), int'(awr));
    e_wr_off = lbus_pkg::wr_off(int'(aw), int'(acs), int'(csw), int'(awr), int'(wrw), ack);
  end

  always_comb begin
    pre_cs = active && (tt < e_cs_on);
    in_cs  = active && (tt >= e_cs_on) && (tt < e_cs_off);
    in_oe  = active && !we && (tt >= e_oe_on) && (tt < e_oe_off);
    in_wr  = active &&  we && (tt >= e_wr_on) && (tt < e_wr_off);
    ale    = active && (tt < int'(aw));
    cs_n   = !in_cs;
    oe_n   = !in_oe;
    wr_n   = !in_wr;
    // Read capture edge: last read-strobe cycle, or the ready edge.
    if (ack) cap_evt = at_cs_last && !hold && !we;
    else     cap_evt = active && !we && (tt == e_oe_off - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= at_cs_last && !hold;
  end

  // R5: the write strobe stays idle during a read
  a_r5_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !we) |-> wr_n);

  // R6: the read strobe stays idle during a write
  a_r6_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active && we) |-> oe_n);

  // R5: the read strobe only appears inside chip select
  a_r5_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n);

  // R10: completion lasts one clock
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: chip select stays low while ready is sampled low
  a_r11_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !cs_n);

endmodule

// File: rtl/lbus_datapath.sv
module lbus_datapath #(
  parameter int DW = 32,
  parameter int NA = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux,
  input  logic          we,
  input  logic          active,
  input  logic          pre_cs,
  input  logic          in_cs,
  input  logic          cap_evt,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe,
  output logic [DW-1:0] rdata
);

  localparam int DL = DW - NA;

  logic span;
  assign span = pre_cs || in_cs;

  always_comb begin
    bus_out = '0;
    bus_oe  = '0;
    if (mux) begin
      if (pre_cs) begin
        bus_out = addr;
        bus_oe  = '1;
      end else if (in_cs && we) begin
        bus_out = wdata;
        bus_oe  = '1;
      end
    end else begin
      bus_out = {wdata[DL-1:0], addr[NA-1:0]};
      bus_oe  = {{DL{span && we}}, {NA{span}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (cap_evt) rdata <= mux ? bus_in : {{NA{1'b0}}, bus_in[DW-1:NA]};
  end

  // R8: the shared bus is released during the read data phase
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mux && !we && in_cs) |-> (bus_oe == '0));

  // R7: data lanes are never driven on a separate-bus read
  a_r7_data_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux && !we) |-> (bus_oe[DW-1:NA] == '0));

endmodule

// File: rtl/lbus_ctrl.sv
module lbus_ctrl #(
  parameter int DW = 32,
  parameter int NA = 24,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mux,
  input  logic          cfg_ack,
  input  logic [CW-1:0] cfg_ale_w,
  input  logic [CW-1:0] cfg_ale_cs,
  input  logic [CW-1:0] cfg_cs_w,
  input  logic [CW-1:0] cfg_cs_oe,
  input  logic [CW-1:0] cfg_oe_cs,
  input  logic [CW-1:0] cfg_ale_wr,
  input  logic [CW-1:0] cfg_wr_w,
  input  logic [CW-1:0] cfg_idle,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_ale,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          bus_wr_n,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe,
  input  logic [DW-1:0] bus_in,
  input  logic          bus_rdy
);

  localparam int TW = CW + 3;

  // Settings and request held for the duration of a transfer.
  logic          r_mux, r_ack, r_we;
  logic [CW-1:0] r_aw, r_acs, r_csw, r_coe, r_ocs, r_awr, r_wrw, r_idl;
  logic [DW-1:0] r_addr, r_wdata;

  // Named internal events.
  logic          active, accept, at_cs_last, hold;
  logic          pre_cs, in_cs, cap_evt;
  logic [TW-1:0] t;

  assign req_ready = !active;
  assign accept    = req_valid && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_mux <= 1'b0; r_ack <= 1'b0; r_we <= 1'b0;
      r_aw  <= '0;   r_acs <= '0;   r_csw <= '0;  r_coe <= '0;
      r_ocs <= '0;   r_awr <= '0;   r_wrw <= '0;  r_idl <= '0;
      r_addr <= '0;  r_wdata <= '0;
    end else if (accept) begin
      r_mux <= cfg_mux;    r_ack <= cfg_ack;    r_we  <= req_we;
      r_aw  <= cfg_ale_w;  r_acs <= cfg_ale_cs; r_csw <= cfg_cs_w;
      r_coe <= cfg_cs_oe;  r_ocs <= cfg_oe_cs;  r_awr <= cfg_ale_wr;
      r_wrw <= cfg_wr_w;   r_idl <= cfg_idle;
      r_addr <= req_addr;  r_wdata <= req_wdata;
    end
  end

  lbus_timer #(.CW(CW), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .ack(r_ack), .rdy(bus_rdy),
    .aw(r_aw), .acs(r_acs), .csw(r_csw), .idl(r_idl),
    .active(active), .t(t), .at_cs_last(at_cs_last), .hold(hold)
  );

  lbus_strobe #(.CW(CW), .TW(TW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .active(active), .t(t), .ack(r_ack), .we(r_we),
    .at_cs_last(at_cs_last), .hold(hold),
    .aw(r_aw), .acs(r_acs), .csw(r_csw), .coe(r_coe), .ocs(r_ocs),
    .awr(r_awr), .wrw(r_wrw),
    .ale(bus_ale), .cs_n(bus_cs_n), .oe_n(bus_oe_n), .wr_n(bus_wr_n),
    .pre_cs(pre_cs), .in_cs(in_cs), .cap_evt(cap_evt), .done(rsp_done)
  );

  lbus_datapath #(.DW(DW), .NA(NA)) u_data (
    .clk(clk), .rst_n(rst_n), .mux(r_mux), .we(r_we), .active(active),
    .pre_cs(pre_cs), .in_cs(in_cs), .cap_evt(cap_evt),
    .addr(r_addr), .wdata(r_wdata), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rdata(rsp_rdata)
  );

  // R2: an accepted request makes the controller busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10: completion never coincides with a low chip select
  a_r10_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> bus_cs_n);

endmodule

// File: tb/sim_lbus_ctrl.sv
module sim_lbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mux, cfg_ack;
  logic [3:0]  cfg_ale_w, cfg_ale_cs, cfg_cs_w, cfg_cs_oe, cfg_oe_cs, cfg_ale_wr, cfg_wr_w, cfg_idle;
  logic        req_valid, req_ready, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        bus_ale, bus_cs_n, bus_oe_n, bus_wr_n;
  logic [31:0] bus_out, bus_oe, bus_in;
  logic        bus_rdy;

  always #5 clk = ~clk;

  lbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_ack(cfg_ack),
    .cfg_ale_w(cfg_ale_w), .cfg_ale_cs(cfg_ale_cs), .cfg_cs_w(cfg_cs_w),
    .cfg_cs_oe(cfg_cs_oe), .cfg_oe_cs(cfg_oe_cs), .cfg_ale_wr(cfg_ale_wr),
    .cfg_wr_w(cfg_wr_w), .cfg_idle(cfg_idle),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_wr_n(bus_wr_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .bus_rdy(bus_rdy)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Bench copy of the settings for the transfer in flight.
  int aw, acs, csw, coe, ocs, awr, wrw, idl, nd;
  bit early, mmux, mack, mwe;
  logic [31:0] maddr, mwdata, rbase, last_rd;

  task automatic chk(string tag, int c, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, c, act, exp);
    end
  endtask

  task automatic set_cfg(int i, bit m, bit k);
    aw  = 1 + (i % 2);
    acs = (i / 2) % 3;
    csw = 3 + (i % 4);
    coe = i % 2;
    ocs = (i / 3) % 2;
    awr = acs + (i % 2);
    wrw = 1 + (i / 5) % 2;
    idl = i % 3;
    nd  = i % 3;
    early = bit'(i % 2);
    mmux = m; mack = k;
    cfg_mux = m; cfg_ack = k;
    cfg_ale_w = 4'(aw);  cfg_ale_cs = 4'(acs); cfg_cs_w = 4'(csw);
    cfg_cs_oe = 4'(coe); cfg_oe_cs = 4'(ocs);  cfg_ale_wr = 4'(awr);
    cfg_wr_w = 4'(wrw);  cfg_idle = 4'(idl);
  endtask

  task automatic issue(bit w, logic [31:0] a, logic [31:0] d);
    mwe = w; maddr = a; mwdata = d;
    req_we = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    chk("R2 ready before accept", -1, 32'(req_ready), 32'd1);
    @(posedge clk); @(negedge clk);
  endtask

  // Walks one transfer from cycle 0, checking every output each cycle.
  task automatic follow(bit hold_next);
    int css, ce, e, cap;
    logic [31:0] eoe, eout, v, erd;
    css = aw + acs;
    ce  = aw + acs + csw;
    e   = ce + (mack ? nd : 0);
    cap = mack ? (e - 1) : (ce - ocs - 1);
    for (int c = 0; c <= e + idl; c++) begin
      chk("R3 ale", c, 32'(bus_ale), 32'(c < aw));
      chk(mack ? "R11 cs" : "R4 cs", c, 32'(bus_cs_n), 32'(!(c >= css && c < e)));
      if (mwe) begin
        chk("R6 oe idle on write", c, 32'(bus_oe_n), 32'd1);
        if (mack) chk("R11 wr", c, 32'(bus_wr_n), 32'(!(c >= aw + awr && c < e)));
        else      chk("R6 wr", c, 32'(bus_wr_n), 32'(!(c >= aw + awr && c < aw + awr + wrw)));
      end else begin
        chk("R5 wr idle on read", c, 32'(bus_wr_n), 32'd1);
        if (mack) chk("R11 oe", c, 32'(bus_oe_n), 32'(!(c >= css + coe && c < e)));
        else      chk("R5 oe", c, 32'(bus_oe_n), 32'(!(c >= css + coe && c < ce - ocs)));
      end
      chk("R2 ready", c, 32'(req_ready), 32'(c >= e + idl));
      chk("R10 done", c, 32'(rsp_done), 32'(c == e));
      if (!mmux) begin
        eoe  = (c < e) ? (mwe ? 32'hFFFF_FFFF : 32'h00FF_FFFF) : 32'h0;
        eout = {mwdata[7:0], maddr[23:0]};
        chk("R7 drive", c, bus_oe, eoe);
        chk("R7 value", c, bus_out & eoe, eout & eoe);
      end else begin
        if (c < css)            begin eoe = 32'hFFFF_FFFF; eout = maddr;  end
        else if (mwe && c < e)  begin eoe = 32'hFFFF_FFFF; eout = mwdata; end
        else                    begin eoe = 32'h0;         eout = 32'h0;  end
        chk("R8 drive", c, bus_oe, eoe);
        chk("R8 value", c, bus_out & eoe, eout & eoe);
      end
      if (c == e) begin
        if (mwe) erd = last_rd;
        else begin
          v   = rbase + 32'(cap) * 32'h0101_0101;
          erd = mmux ? v : {24'h0, v[31:24]};
        end
        chk(mack ? "R12 rdata" : "R9 rdata", c, rsp_rdata, erd);
        last_rd = erd;
      end
      if (c < e + idl) begin
        req_valid = hold_next;
        bus_in = rbase + 32'(c) * 32'h0101_0101;
        bus_rdy = (c < ce - 1) ? early : (c >= ce - 1 + nd);
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0; bus_in = '0; bus_rdy = 1'b0;
    last_rd = '0; rbase = '0;
    set_cfg(0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk("R1 ale", 0, 32'(bus_ale), 32'd0);
    chk("R1 cs", 0, 32'(bus_cs_n), 32'd1);
    chk("R1 oe", 0, 32'(bus_oe_n), 32'd1);
    chk("R1 wr", 0, 32'(bus_wr_n), 32'd1);
    chk("R1 drive", 0, bus_oe, 32'd0);
    chk("R1 done", 0, 32'(rsp_done), 32'd0);
    chk("R1 ready", 0, 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 0, 32'(req_ready), 32'd1);

    for (int i = 0; i < 24; i++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 2; k++)
          for (int w = 0; w < 2; w++) begin
            set_cfg(i, bit'(m), bit'(k));
            rbase = 32'h1357_9BDF + 32'(i) * 32'h0F1E_2D3C + 32'(m * 7 + k * 3);
            issue(bit'(w), 32'hC0A8_0000 ^ (32'(i) << 4) ^ 32'(m),
                  32'h5AA5_3CC3 + 32'(i) * 32'h0011_2233);
            follow(1'b0);
          end

    // R2: a request presented while busy is accepted later, not dropped.
    for (int i = 0; i < 6; i++) begin
      set_cfg(i, bit'(i % 2), bit'(i / 3));
      rbase = 32'h2468_ACE0 + 32'(i);
      issue(bit'(i % 2), 32'h0012_3456 + 32'(i), 32'hDEAD_BE00 + 32'(i));
      follow(1'b1);
      @(posedge clk); @(negedge clk);
      chk("R2 held request started", 0, 32'(bus_ale), 32'd1);
      follow(1'b0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule